// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small, fully associative store placed next to a direct-mapped cache array. Each time the array reports a miss, it presents the requested block address along with the line it is about to overwrite. One cycle later the buffer answers. On a hit, the buffer hands the requested line back so the array can install it. In the same operation, the overwritten line takes the slot that the hit entry occupied. Two blocks that share a set and are used alternately then trade places between the array and the buffer, and neither has to be fetched again from the next level.

When the requested block is in neither structure, the buffer raises a forward request with the block address for the next memory level. It also keeps the overwritten line. Empty slots are used first. Once every slot is occupied, the entry that has been in the buffer longest, counted from when it was inserted, gives way. A line that comes in through a swap counts as a new insertion. The search happens after the array miss is known, so a miss in both structures reaches the next level one cycle later than it would with no buffer.

Top module: `vbuf_top`

## Requirements
- R1: After reset every entry is empty, `rsp_valid_o` and `fwd_valid_o` are low, and the first lookup misses.
- R2: `rsp_valid_o` is high in exactly the cycle after a cycle in which `lkp_valid_i` was sampled high.
- R3: When a lookup address matches a stored entry, `rsp_hit_o` is 1 and `swap_addr_o`/`swap_data_o` carry that entry's address and line data.
- R4: On a hit with `ev_valid_i` high, the evicted line takes the hit entry's place, and a later lookup of the evicted address hits and returns its data.
- R5: On a miss, `rsp_hit_o` is 0, `fwd_valid_o` is 1 and `fwd_addr_o` equals the lookup address. `fwd_valid_o` is never high without a miss response.
- R6: On a miss with `ev_valid_i` high, the evicted line is stored and a later lookup of it hits.
- R7: While any entry is empty, a new line goes into an empty entry and no stored line is lost.
- R8: When all entries are full, a new line replaces the entry inserted earliest. Lines that arrive through a swap count as inserted at the time of the swap.
- R9: On a hit with `ev_valid_i` low, the hit entry is removed, and a later lookup of that address misses.
- R10: A cycle with `lkp_valid_i` low changes no stored entry and raises neither `rsp_valid_o` nor `fwd_valid_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | The main array missed on `lkp_addr_i` |
| lkp_addr_i | input | ADDR_W | Requested block address |
| ev_valid_i | input | 1 | The array is overwriting a valid line |
| ev_addr_i | input | ADDR_W | Block address of the overwritten line |
| ev_data_i | input | DATA_W | Data of the overwritten line |
| rsp_valid_o | output | 1 | Lookup result is valid this cycle |
| rsp_hit_o | output | 1 | Lookup hit in the buffer |
| swap_addr_o | output | ADDR_W | Address of the line returned to the array (valid on hit) |
| swap_data_o | output | DATA_W | Data of the line returned to the array (valid on hit) |
| fwd_valid_o | output | 1 | Request to the next level |
| fwd_addr_o | output | ADDR_W | Block address requested from the next level |

## Verification
The hardest case to reach is a full buffer in which a swap has changed the insertion order just before a miss forces a replacement. A wrong choice of victim shows up only several lookups later, as a miss where a hit was due. A directed sequence fills all four entries, swaps on one of the middle entries, and then forces a miss with an eviction. It then probes the entry that should have left and the ones that should remain. The random phase draws lookup addresses from a small pool so that hits, swaps, removals and full-buffer replacements follow one another closely. Every response is compared with a first-in first-out queue model kept in the bench.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;

  // Outcome of a lookup, decided in the cycle the lookup is sampled.
  typedef enum logic [1:0] {
    VB_IDLE = 2'd0,
    VB_HIT  = 2'd1,
    VB_MISS = 2'd2
  } vb_outcome_e;

endpackage

// File: rtl/vbuf_tag_match.sv
module vbuf_tag_match #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ENTRIES-1:0]             vld_i,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_i,
  input  logic [ADDR_W-1:0]              addr_i,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               hit_idx_o
);

  logic [ENTRIES-1:0] match_vec;

  // One comparator for each entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = vld_i[g] && (tag_i[g] == addr_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |match_vec;

  // R3: no address is ever held in two valid entries, so a match is unique.
  assert_unique_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

endmodule

// File: rtl/vbuf_victim_pick.sv
module vbuf_victim_pick #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            vld_i,
  input  logic [ENTRIES-1:0][IDX_W-1:0] age_i,
  output logic [IDX_W-1:0]              victim_o,
  output logic                          victim_was_valid_o
);

  logic              any_free;
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  old_idx;

  // The lowest-numbered empty slot is chosen first.
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // With every slot full the ages are distinct and the oldest one has the top rank.
  always_comb begin
    old_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_i[i] && (age_i[i] == IDX_W'(ENTRIES - 1))) old_idx = IDX_W'(i);
    end
  end

  assign victim_o           = any_free ? free_idx : old_idx;
  assign victim_was_valid_o = !any_free;

endmodule

// File: rtl/vbuf_age_ctrl.sv
module vbuf_age_ctrl #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            vld_i,
  input  logic                          ins_en_i,
  input  logic [IDX_W-1:0]              ins_idx_i,
  input  logic                          ins_was_valid_i,
  input  logic                          kill_en_i,
  input  logic [IDX_W-1:0]              kill_idx_i,
  output logic [ENTRIES-1:0][IDX_W-1:0] age_o
);

  logic [ENTRIES-1:0][IDX_W-1:0] age_q, age_d;
  logic                          upd_en;

  assign upd_en = ins_en_i || kill_en_i;

  // Rank 0 is the newest insertion. The ranks of valid entries stay distinct.
  always_comb begin
    age_d = age_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ins_en_i) begin
        if (IDX_W'(i) == ins_idx_i) begin
          age_d[i] = '0;
        end else if (vld_i[i] && (!ins_was_valid_i || (age_q[i] < age_q[ins_idx_i]))) begin
          age_d[i] = age_q[i] + 1'b1;
        end
      end
      if (kill_en_i && vld_i[i] && (IDX_W'(i) != kill_idx_i) &&
          (age_q[i] > age_q[kill_idx_i])) begin
        age_d[i] = age_q[i] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (upd_en) begin
      age_q <= age_d;
    end
  end

  assign age_o = age_q;

  // R8: an insertion and a removal never fall in the same cycle.
  assert_single_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_en_i && kill_en_i));

endmodule

// File: rtl/vbuf_top.sv
module vbuf_top #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  input  logic              ev_valid_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic [DATA_W-1:0] ev_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [ADDR_W-1:0] swap_addr_o,
  output logic [DATA_W-1:0] swap_data_o,
  output logic              fwd_valid_o,
  output logic [ADDR_W-1:0] fwd_addr_o
);
  import vbuf_pkg::*;

  // Entry storage
  logic [ENTRIES-1:0]             vld_q, vld_d;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] dat_q;
  logic [ENTRIES-1:0][IDX_W-1:0]  age;

  // Search and victim choice
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim;
  logic              victim_was_valid;
  vb_outcome_e       outcome;

  // Write controls
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic              ins_en;
  logic              ins_was_valid;
  logic              kill_en;

  // Response registers
  logic              rsp_valid_q, rsp_hit_q, fwd_valid_q;
  logic [ADDR_W-1:0] swap_addr_q, fwd_addr_q;
  logic [DATA_W-1:0] swap_data_q;

  vbuf_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld_i     (vld_q),
    .tag_i     (tag_q),
    .addr_i    (lkp_addr_i),
    .hit_o     (hit),
    .hit_idx_o (hit_idx)
  );

  vbuf_victim_pick #(.ENTRIES(ENTRIES)) u_pick (
    .vld_i              (vld_q),
    .age_i              (age),
    .victim_o           (victim),
    .victim_was_valid_o (victim_was_valid)
  );

  vbuf_age_ctrl #(.ENTRIES(ENTRIES)) u_age (
    .clk             (clk),
    .rst_n           (rst_n),
    .vld_i           (vld_q),
    .ins_en_i        (ins_en),
    .ins_idx_i       (wr_idx),
    .ins_was_valid_i (ins_was_valid),
    .kill_en_i       (kill_en),
    .kill_idx_i      (hit_idx),
    .age_o           (age)
  );

  always_comb begin
    if (!lkp_valid_i) outcome = VB_IDLE;
    else if (hit)     outcome = VB_HIT;
    else              outcome = VB_MISS;
  end

  // Next-state decisions
  always_comb begin
    vld_d         = vld_q;
    wr_en         = 1'b0;
    wr_idx        = victim;
    ins_en        = 1'b0;
    ins_was_valid = victim_was_valid;
    kill_en       = 1'b0;
    unique case (outcome)
      VB_HIT: begin
        wr_idx = hit_idx;
        if (ev_valid_i) begin
          // Swap: the overwritten line takes the slot and counts as newest.
          wr_en         = 1'b1;
          ins_en        = 1'b1;
          ins_was_valid = 1'b1;
        end else begin
          kill_en         = 1'b1;
          vld_d[hit_idx]  = 1'b0;
        end
      end
      VB_MISS: begin
        if (ev_valid_i) begin
          wr_en          = 1'b1;
          ins_en         = 1'b1;
          vld_d[victim]  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (lkp_valid_i) begin
      vld_q <= vld_d;
    end
  end

  // Tag and data arrays: no reset, written only with their enable.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= ev_addr_i;
      dat_q[wr_idx] <= ev_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      fwd_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= lkp_valid_i;
      rsp_hit_q   <= (outcome == VB_HIT);
      fwd_valid_q <= (outcome == VB_MISS);
    end
  end

  always_ff @(posedge clk) begin
    if (outcome == VB_HIT) begin
      swap_addr_q <= tag_q[hit_idx];
      swap_data_q <= dat_q[hit_idx];
    end
    if (outcome == VB_MISS) begin
      fwd_addr_q <= lkp_addr_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign swap_addr_o = swap_addr_q;
  assign swap_data_o = swap_data_q;
  assign fwd_valid_o = fwd_valid_q;
  assign fwd_addr_o  = fwd_addr_q;

  // R2: a response follows every lookup one cycle later.
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid_i |=> rsp_valid_o);

  // R10: an idle cycle leaves the entries alone and produces no response.
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid_i |=> (!rsp_valid_o && !fwd_valid_o && $stable(vld_q)));

  // R5: a forward request appears only together with a miss response.
  assert_fwd_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid_o |-> (rsp_valid_o && !rsp_hit_o));

  // R7: while there is room, storing a line raises the occupancy by one.
  assert_fill_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid_i && !hit && ev_valid_i && ($countones(vld_q) < ENTRIES))
      |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));

  // R9: a hit without an incoming line lowers the occupancy by one.
  assert_remove_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid_i && hit && !ev_valid_i)
      |=> ($countones(vld_q) + 1 == $countones($past(vld_q))));

endmodule

// File: tb/vbuf_top_tb.sv
module vbuf_top_tb_top;

  localparam int N  = 4;
  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic          lkp_valid;
  logic [AW-1:0] lkp_addr;
  logic          ev_valid;
  logic [AW-1:0] ev_addr;
  logic [DW-1:0] ev_data;
  logic          rsp_valid, rsp_hit, fwd_valid;
  logic [AW-1:0] swap_addr, fwd_addr;
  logic [DW-1:0] swap_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // FIFO model: slot 0 holds the oldest insertion.
  logic [AW-1:0] m_addr [N];
  logic [DW-1:0] m_data [N];
  int            m_n = 0;

  // Next-level stub: one forward request counted per miss.
  int fwd_seen = 0;

  vbuf_top #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_addr_i(lkp_addr),
    .ev_valid_i(ev_valid), .ev_addr_i(ev_addr), .ev_data_i(ev_data),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .swap_addr_o(swap_addr), .swap_data_o(swap_data),
    .fwd_valid_o(fwd_valid), .fwd_addr_o(fwd_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) if (fwd_valid) fwd_seen <= fwd_seen + 1;

  function automatic int model_find(logic [AW-1:0] a);
    for (int i = 0; i < m_n; i++) if (m_addr[i] == a) return i;
    return -1;
  endfunction

  function automatic void model_remove(int k);
    for (int i = k; i < N - 1; i++) begin
      m_addr[i] = m_addr[i+1];
      m_data[i] = m_data[i+1];
    end
    m_n--;
  endfunction

  function automatic void model_push(logic [AW-1:0] a, logic [DW-1:0] d);
    if (m_n == N) model_remove(0);
    m_addr[m_n] = a;
    m_data[m_n] = d;
    m_n++;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One lookup: drive at a falling edge, check after the next rising edge.
  task automatic lookup(string req, logic [AW-1:0] a, logic ev, logic [AW-1:0] ea,
                        logic [DW-1:0] ed);
    int            k;
    logic          exp_hit;
    logic [DW-1:0] exp_data;
    k        = model_find(a);
    exp_hit  = (k >= 0);
    exp_data = exp_hit ? m_data[k] : '0;
    if (exp_hit) model_remove(k);
    if (ev) model_push(ea, ed);
    lkp_valid = 1'b1; lkp_addr = a; ev_valid = ev; ev_addr = ea; ev_data = ed;
    @(negedge clk);
    lkp_valid = 1'b0;
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"}, 32'(rsp_hit), 32'(exp_hit));
    check({req, " fwd_valid"}, 32'(fwd_valid), 32'(!exp_hit));
    if (exp_hit) begin
      check({req, " swap_addr"}, 32'(swap_addr), 32'(a));
      check({req, " swap_data"}, 32'(swap_data), 32'(exp_data));
    end else begin
      check({req, " fwd_addr"}, 32'(fwd_addr), 32'(a));
    end
  endtask

  task automatic idle(string req);
    lkp_valid = 1'b0;
    ev_valid  = 1'b1;
    ev_addr   = AW'($urandom);
    ev_data   = DW'($urandom);
    lkp_addr  = AW'($urandom);
    @(negedge clk);
    check({req, " idle rsp_valid"}, 32'(rsp_valid), 32'd0);
    check({req, " idle fwd_valid"}, 32'(fwd_valid), 32'd0);
  endtask

  function automatic logic [DW-1:0] line_of(logic [AW-1:0] a);
    return {a, 8'h00} ^ DW'($urandom);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; lkp_valid = 1'b0; lkp_addr = '0;
    ev_valid = 1'b0; ev_addr = '0; ev_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 reset fwd_valid", 32'(fwd_valid), 32'd0);
    lookup("R1", 8'h10, 1'b0, 8'h00, 16'h0);

    // R6 and R7: fill three slots, remove the middle one, then refill.
    lookup("R6", 8'h20, 1'b1, 8'h01, 16'hA001);
    lookup("R6", 8'h21, 1'b1, 8'h02, 16'hA002);
    lookup("R7", 8'h22, 1'b1, 8'h03, 16'hA003);
    lookup("R9", 8'h02, 1'b0, 8'h00, 16'h0);
    lookup("R9", 8'h02, 1'b0, 8'h00, 16'h0);
    idle("R10");
    lookup("R7", 8'h23, 1'b1, 8'h04, 16'hA004);
    lookup("R7", 8'h24, 1'b1, 8'h05, 16'hA005);
    lookup("R7", 8'h01, 1'b1, 8'h06, 16'hA006);

    // R4 and R8: full buffer, swap on a middle entry, then a forced replacement.
    lookup("R4", 8'h04, 1'b1, 8'h07, 16'hA007);
    lookup("R8", 8'h30, 1'b1, 8'h08, 16'hA008);
    lookup("R8", 8'h03, 1'b1, 8'h09, 16'hA009);
    lookup("R4", 8'h07, 1'b1, 8'h0A, 16'hA00A);
    idle("R10");
    lookup("R3", 8'h05, 1'b1, 8'h0B, 16'hA00B);

    // Random phase over a small address pool.
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a, ea;
      logic          ev;
      a  = AW'($urandom_range(0, 11));
      ev = ($urandom_range(0, 9) < 8);
      do ea = AW'($urandom_range(0, 15));
      while ((ea == a) || (model_find(ea) >= 0));
      if ($urandom_range(0, 19) == 0) idle("R10");
      lookup("R8 random", a, ev, ea, line_of(ea));
    end

    check("R5 stub saw requests", 32'(fwd_seen > 0), 32'd1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule